// File: doc/BRIEF.md
# Double-Buffer Transfer Controller

The controller copies one word from a fixed timer-peripheral address into main memory each time the timer raises a request. It owns two control packets, A and B. Both packets share one peripheral source address and one element count. Each packet has its own initial memory address, a live current address and a live frame counter. Only one packet is active at a time. The active packet's current address is the destination of the next transfer. After each completed frame, that address advances by one word and the frame counter advances by one.

Each packet has its own end-of-buffer behaviour:
- **one-shot**: transfers stop.
- **auto-switch**: the other packet takes over.
- **circular**: the packet wraps to its start.

Combining the two modes builds a single buffer, a buffer of double length, a ping-pong pair, or two rings that software swaps at will. Whenever a packet is made active, it restarts from its initial address with a zero count. While a packet is idle, its counter and address hold still, so software can read how full its buffer is. Software can also rewrite them.

Software reaches the block through a small register port with combinational read data. Through it, software selects the active packet, sets the modes, reads sticky buffer-full and lost-request flags, and watches a busy bit that lasts until any transfer in flight has finished.

Top module: `dbuf_xfer`

## Requirements
- R1: After reset no packet is active, `xfer_req_o` and `irq_o` are low, and the status register (address 10) reads 0.
- R2: Writing the select register (address 0) makes A active when bit 0 is 1, makes B active when bit 0 is 0 and bit 1 is 1, and makes neither active when both bits are 0. Reading it returns bit 0 = A active and bit 1 = B active.
- R3: When a packet becomes active, its current address (A: address 6, B: 7) becomes its initial address (A: 4, B: 5) and its frame counter (A: 8, B: 9) becomes 0. Rewriting the select register with the packet that is already active leaves both values unchanged.
- R4: A request while a packet is active and no transfer is pending raises `xfer_req_o`. `xfer_dst_o` carries that packet's current address and `xfer_src_o` carries the peripheral address (address 2). Both hold until `xfer_ack_i`. A request while no packet is active is ignored.
- R5: Each acknowledged transfer adds 4 to the owning packet's current address and 1 to its frame counter.
- R6: Modes are set in address 1: bits [1:0] for A and bits [3:2] for B, with 0 = one-shot, 1 = auto-switch and 2 = circular. The buffer end is the acknowledge that brings the counter to the element count (address 3). In one-shot mode the buffer end deactivates the packet and leaves the counter at the element count.
- R7: In auto-switch mode the buffer end makes the other packet active.
- R8: In circular mode the buffer end returns the packet to its initial address with count 0, and the packet stays active.
- R9: Busy (status bit 4 for A, bit 5 for B) is set while the packet is active. It stays set after the packet is deselected until its pending transfer is acknowledged.
- R10: An inactive packet's address and counter do not change on requests. The CPU can overwrite them, including to 0.
- R11: Status bit 0 (A) or bit 1 (B) is set at that packet's buffer end in every mode and stays set until a 1 is written to it. `irq_o` is high when a set flag has its enable bit set in address 1 (bit 4 for A, bit 5 for B).
- R12: A request that arrives while a transfer is still pending is dropped and sets the active packet's lost flag (status bit 2 for A, bit 3 for B). Writing 1 to that bit clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Transfer request from the timer |
| xfer_req_o | output | 1 | Transfer pending toward the memory side |
| xfer_src_o | output | ADDR_W | Peripheral source address |
| xfer_dst_o | output | ADDR_W | Memory destination address |
| xfer_ack_i | input | 1 | Pending transfer completed |
| cpu_we_i | input | 1 | Register write strobe |
| cpu_addr_i | input | REG_AW | Register index |
| cpu_wdata_i | input | ADDR_W | Register write data |
| cpu_rdata_o | output | ADDR_W | Register read data (combinational) |
| irq_o | output | 1 | Buffer-full interrupt |

## Verification
The embedded assertions assume two things about the environment. First, `xfer_ack_i` arrives only while `xfer_req_o` is high and lasts a single cycle. Second, the element count is at least 1, so a buffer end can actually be reached. The bench acknowledges only transfers it has observed pending, and only once each. It programs a count of 3. It never writes a current register in the same cycle as an acknowledge. Overlapping requests are produced deliberately by stretching the acknowledge delay, so that the drop and busy-drain paths are exercised within these assumptions.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;

  typedef enum logic [1:0] {
    MODE_ONESHOT = 2'd0,
    MODE_AUTO    = 2'd1,
    MODE_CIRC    = 2'd2,
    MODE_RSVD    = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_A    = 2'd1,
    ACT_B    = 2'd2
  } act_e;

  localparam int unsigned RA_SEL    = 0;
  localparam int unsigned RA_CFG    = 1;
  localparam int unsigned RA_PADDR  = 2;
  localparam int unsigned RA_TCNT   = 3;
  localparam int unsigned RA_IADR_A = 4;
  localparam int unsigned RA_IADR_B = 5;
  localparam int unsigned RA_CADR_A = 6;
  localparam int unsigned RA_CADR_B = 7;
  localparam int unsigned RA_CCNT_A = 8;
  localparam int unsigned RA_CCNT_B = 9;
  localparam int unsigned RA_STAT   = 10;

  function automatic act_e pick_sel(input logic [1:0] sel);
    if (sel[0])      return ACT_A;
    else if (sel[1]) return ACT_B;
    else             return ACT_NONE;
  endfunction

  function automatic act_e after_end(input act_e cur, input mode_e m);
    case (m)
      MODE_AUTO: return (cur == ACT_A) ? ACT_B : ACT_A;
      MODE_CIRC: return cur;
      default:   return ACT_NONE;
    endcase
  endfunction

endpackage

// File: rtl/dbuf_packet.sv
module dbuf_packet #(
  parameter int AW         = 32,
  parameter int CW         = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  dbuf_pkg::mode_e      mode_i,
  input  logic [AW-1:0]        init_addr_i,
  input  logic [CW-1:0]        tcount_i,
  input  logic                 load_i,
  input  logic                 ack_i,
  input  logic                 addr_we_i,
  input  logic                 cnt_we_i,
  input  logic [AW-1:0]        wdata_i,
  input  logic                 full_clr_i,
  input  logic                 lost_set_i,
  input  logic                 lost_clr_i,
  output logic [AW-1:0]        caddr_o,
  output logic [CW-1:0]        cnt_o,
  output logic                 full_o,
  output logic                 lost_o,
  output logic                 end_o
);
  import dbuf_pkg::*;

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return a + AW'(WORD_BYTES);
  endfunction

  function automatic logic [CW-1:0] bump_count(input logic [CW-1:0] c);
    return c + CW'(1);
  endfunction

  function automatic logic at_end(input logic [CW-1:0] c, input logic [CW-1:0] lim);
    return c == lim;
  endfunction

  logic [AW-1:0] caddr_q;
  logic [CW-1:0] cnt_q;
  logic          full_q, lost_q;
  logic [CW-1:0] cnt_inc;
  logic          wrap;

  assign cnt_inc = bump_count(cnt_q);
  assign end_o   = ack_i && at_end(cnt_inc, tcount_i);
  assign wrap    = end_o && (mode_i == MODE_CIRC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      caddr_q <= '0;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      lost_q  <= 1'b0;
    end else begin
      if (addr_we_i) caddr_q <= wdata_i;
      if (cnt_we_i)  cnt_q   <= wdata_i[CW-1:0];
      if (ack_i) begin
        if (wrap) begin
          caddr_q <= init_addr_i;
          cnt_q   <= '0;
        end else begin
          caddr_q <= step_addr(caddr_q);
          cnt_q   <= cnt_inc;
        end
      end
      if (load_i) begin
        caddr_q <= init_addr_i;
        cnt_q   <= '0;
      end
      if (end_o)           full_q <= 1'b1;
      else if (full_clr_i) full_q <= 1'b0;
      if (lost_set_i)      lost_q <= 1'b1;
      else if (lost_clr_i) lost_q <= 1'b0;
    end
  end

  assign caddr_o = caddr_q;
  assign cnt_o   = cnt_q;
  assign full_o  = full_q;
  assign lost_o  = lost_q;

  AST_LOAD_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (caddr_o == $past(init_addr_i)) && (cnt_o == '0)); // R3
  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i && !load_i && !end_o |=> (caddr_o == $past(caddr_o) + AW'(WORD_BYTES)) && (cnt_o == $past(cnt_o) + CW'(1))); // R5
  AST_CIRC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    end_o && (mode_i == MODE_CIRC) && !load_i |=> (cnt_o == '0) && (caddr_o == $past(init_addr_i))); // R8
  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    full_o && !full_clr_i |=> full_o); // R11

endmodule

// File: rtl/dbuf_seq.sv
module dbuf_seq #(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_we_i,
  input  logic [1:0]        sel_i,
  input  logic              req_i,
  input  logic              ack_i,
  input  logic              end_a_i,
  input  logic              end_b_i,
  input  dbuf_pkg::mode_e   mode_a_i,
  input  dbuf_pkg::mode_e   mode_b_i,
  input  logic [AW-1:0]     caddr_a_i,
  input  logic [AW-1:0]     caddr_b_i,
  output dbuf_pkg::act_e    active_o,
  output logic              load_a_o,
  output logic              load_b_o,
  output logic              ack_a_o,
  output logic              ack_b_o,
  output logic              lost_a_o,
  output logic              lost_b_o,
  output logic              busy_a_o,
  output logic              busy_b_o,
  output logic              xfer_req_o,
  output logic [AW-1:0]     xfer_dst_o
);
  import dbuf_pkg::*;

  act_e          active_q, act_d, owner_q;
  logic          pend_q;
  logic [AW-1:0] dst_q;
  logic          issue, drop, fin_act;
  mode_e         cur_mode;

  assign issue    = req_i && (active_q != ACT_NONE) && !pend_q;
  assign drop     = req_i && (active_q != ACT_NONE) && pend_q;
  assign ack_a_o  = ack_i && pend_q && (owner_q == ACT_A);
  assign ack_b_o  = ack_i && pend_q && (owner_q == ACT_B);
  assign fin_act  = (owner_q == active_q) && (end_a_i || end_b_i);
  assign cur_mode = (active_q == ACT_B) ? mode_b_i : mode_a_i;

  always_comb begin
    act_d = active_q;
    if (sel_we_i)     act_d = pick_sel(sel_i);
    else if (fin_act) act_d = after_end(active_q, cur_mode);
  end

  assign load_a_o = (act_d == ACT_A) && (active_q != ACT_A);
  assign load_b_o = (act_d == ACT_B) && (active_q != ACT_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= ACT_NONE;
      owner_q  <= ACT_NONE;
      pend_q   <= 1'b0;
      dst_q    <= '0;
    end else begin
      active_q <= act_d;
      if (issue) begin
        pend_q  <= 1'b1;
        owner_q <= active_q;
        dst_q   <= (active_q == ACT_B) ? caddr_b_i : caddr_a_i;
      end else if (ack_i && pend_q) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign lost_a_o   = drop && (active_q == ACT_A);
  assign lost_b_o   = drop && (active_q == ACT_B);
  assign busy_a_o   = (active_q == ACT_A) || (pend_q && owner_q == ACT_A);
  assign busy_b_o   = (active_q == ACT_B) || (pend_q && owner_q == ACT_B);
  assign active_o   = active_q;
  assign xfer_req_o = pend_q;
  assign xfer_dst_o = dst_q;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req_o && !ack_i |=> xfer_req_o && $stable(xfer_dst_o)); // R4
  AST_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_req_o && (active_o == ACT_NONE) |=> !xfer_req_o); // R4
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    fin_act && (cur_mode == MODE_ONESHOT) && !sel_we_i |=> active_o == ACT_NONE); // R6
  AST_AUTO_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    fin_act && (cur_mode == MODE_AUTO) && !sel_we_i && (active_o == ACT_A) |=> active_o == ACT_B); // R7
  AST_BUSY_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req_o && !ack_i && (owner_q == ACT_A) |=> busy_a_o); // R9

endmodule

// File: rtl/dbuf_xfer.sv
module dbuf_xfer #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int REG_AW     = 4,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  output logic              xfer_req_o,
  output logic [ADDR_W-1:0] xfer_src_o,
  output logic [ADDR_W-1:0] xfer_dst_o,
  input  logic              xfer_ack_i,
  input  logic              cpu_we_i,
  input  logic [REG_AW-1:0] cpu_addr_i,
  input  logic [ADDR_W-1:0] cpu_wdata_i,
  output logic [ADDR_W-1:0] cpu_rdata_o,
  output logic              irq_o
);
  import dbuf_pkg::*;

  localparam int CFG_W = 6;

  logic [CFG_W-1:0]  cfg_q;
  logic [ADDR_W-1:0] paddr_q, iadr_a_q, iadr_b_q;
  logic [CNT_W-1:0]  tcnt_q;

  mode_e mode_a, mode_b;
  act_e  active;
  logic  ie_a, ie_b;

  logic [ADDR_W-1:0] caddr_a, caddr_b;
  logic [CNT_W-1:0]  cnt_a, cnt_b;
  logic full_a, full_b, lost_a, lost_b, end_a, end_b;
  logic load_a, load_b, ack_a, ack_b, lset_a, lset_b, busy_a, busy_b;

  function automatic logic hit(input logic [REG_AW-1:0] a, input int unsigned ra);
    return a == REG_AW'(ra);
  endfunction

  logic wr_sel, wr_stat;
  assign wr_sel  = cpu_we_i && hit(cpu_addr_i, RA_SEL);
  assign wr_stat = cpu_we_i && hit(cpu_addr_i, RA_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      paddr_q  <= '0;
      tcnt_q   <= '0;
      iadr_a_q <= '0;
      iadr_b_q <= '0;
    end else if (cpu_we_i) begin
      if (hit(cpu_addr_i, RA_CFG))    cfg_q    <= cpu_wdata_i[CFG_W-1:0];
      if (hit(cpu_addr_i, RA_PADDR))  paddr_q  <= cpu_wdata_i;
      if (hit(cpu_addr_i, RA_TCNT))   tcnt_q   <= cpu_wdata_i[CNT_W-1:0];
      if (hit(cpu_addr_i, RA_IADR_A)) iadr_a_q <= cpu_wdata_i;
      if (hit(cpu_addr_i, RA_IADR_B)) iadr_b_q <= cpu_wdata_i;
    end
  end

  assign mode_a = mode_e'(cfg_q[1:0]);
  assign mode_b = mode_e'(cfg_q[3:2]);
  assign ie_a   = cfg_q[4];
  assign ie_b   = cfg_q[5];

  dbuf_seq #(.AW(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .sel_we_i(wr_sel), .sel_i(cpu_wdata_i[1:0]),
    .req_i(req_i), .ack_i(xfer_ack_i),
    .end_a_i(end_a), .end_b_i(end_b),
    .mode_a_i(mode_a), .mode_b_i(mode_b),
    .caddr_a_i(caddr_a), .caddr_b_i(caddr_b),
    .active_o(active),
    .load_a_o(load_a), .load_b_o(load_b),
    .ack_a_o(ack_a), .ack_b_o(ack_b),
    .lost_a_o(lset_a), .lost_b_o(lset_b),
    .busy_a_o(busy_a), .busy_b_o(busy_b),
    .xfer_req_o(xfer_req_o), .xfer_dst_o(xfer_dst_o)
  );

  dbuf_packet #(.AW(ADDR_W), .CW(CNT_W), .WORD_BYTES(WORD_BYTES)) u_pkt_a (
    .clk(clk), .rst_n(rst_n),
    .mode_i(mode_a), .init_addr_i(iadr_a_q), .tcount_i(tcnt_q),
    .load_i(load_a), .ack_i(ack_a),
    .addr_we_i(cpu_we_i && hit(cpu_addr_i, RA_CADR_A)),
    .cnt_we_i(cpu_we_i && hit(cpu_addr_i, RA_CCNT_A)),
    .wdata_i(cpu_wdata_i),
    .full_clr_i(wr_stat && cpu_wdata_i[0]),
    .lost_set_i(lset_a), .lost_clr_i(wr_stat && cpu_wdata_i[2]),
    .caddr_o(caddr_a), .cnt_o(cnt_a), .full_o(full_a), .lost_o(lost_a), .end_o(end_a)
  );

  dbuf_packet #(.AW(ADDR_W), .CW(CNT_W), .WORD_BYTES(WORD_BYTES)) u_pkt_b (
    .clk(clk), .rst_n(rst_n),
    .mode_i(mode_b), .init_addr_i(iadr_b_q), .tcount_i(tcnt_q),
    .load_i(load_b), .ack_i(ack_b),
    .addr_we_i(cpu_we_i && hit(cpu_addr_i, RA_CADR_B)),
    .cnt_we_i(cpu_we_i && hit(cpu_addr_i, RA_CCNT_B)),
    .wdata_i(cpu_wdata_i),
    .full_clr_i(wr_stat && cpu_wdata_i[1]),
    .lost_set_i(lset_b), .lost_clr_i(wr_stat && cpu_wdata_i[3]),
    .caddr_o(caddr_b), .cnt_o(cnt_b), .full_o(full_b), .lost_o(lost_b), .end_o(end_b)
  );

  always_comb begin
    cpu_rdata_o = '0;
    case (cpu_addr_i)
      REG_AW'(RA_SEL):    cpu_rdata_o = ADDR_W'({active == ACT_B, active == ACT_A});
      REG_AW'(RA_CFG):    cpu_rdata_o = ADDR_W'(cfg_q);
      REG_AW'(RA_PADDR):  cpu_rdata_o = paddr_q;
      REG_AW'(RA_TCNT):   cpu_rdata_o = ADDR_W'(tcnt_q);
      REG_AW'(RA_IADR_A): cpu_rdata_o = iadr_a_q;
      REG_AW'(RA_IADR_B): cpu_rdata_o = iadr_b_q;
      REG_AW'(RA_CADR_A): cpu_rdata_o = caddr_a;
      REG_AW'(RA_CADR_B): cpu_rdata_o = caddr_b;
      REG_AW'(RA_CCNT_A): cpu_rdata_o = ADDR_W'(cnt_a);
      REG_AW'(RA_CCNT_B): cpu_rdata_o = ADDR_W'(cnt_b);
      REG_AW'(RA_STAT):   cpu_rdata_o = ADDR_W'({busy_b, busy_a, lost_b, lost_a, full_b, full_a});
      default:            cpu_rdata_o = '0;
    endcase
  end

  assign xfer_src_o = paddr_q;
  assign irq_o      = (full_a && ie_a) || (full_b && ie_b);

  logic unused_wdata;
  assign unused_wdata = ^cpu_wdata_i;

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (full_a || full_b)); // R11
  AST_LOST_ON_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && xfer_req_o && (active == ACT_A) |=> lost_a); // R12
  AST_FULL_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    end_b |=> full_b); // R11

endmodule

// File: tb/dbuf_xfer_bench.sv
module dbuf_xfer_bench;
  localparam int AW  = 32;
  localparam int CW  = 16;
  localparam int RAW = 4;
  localparam logic [AW-1:0] PADDR = 32'h4000_1000;
  localparam logic [AW-1:0] IA    = 32'h0000_0100;
  localparam logic [AW-1:0] IB    = 32'h0000_0200;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, ack = 1'b0, we = 1'b0;
  logic [RAW-1:0] addr = '0;
  logic [AW-1:0]  wdata = '0;
  logic           xfer_req, irq;
  logic [AW-1:0]  src, dst, rdata;

  dbuf_xfer #(.ADDR_W(AW), .CNT_W(CW), .REG_AW(RAW)) u_dbuf_xfer (
    .clk(clk), .rst_n(rst_n), .req_i(req),
    .xfer_req_o(xfer_req), .xfer_src_o(src), .xfer_dst_o(dst), .xfer_ack_i(ack),
    .cpu_we_i(we), .cpu_addr_i(addr), .cpu_wdata_i(wdata), .cpu_rdata_o(rdata),
    .irq_o(irq)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0, ack_delay = 0;
  logic [AW-1:0] expq[$];

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic wr(input int a, input logic [AW-1:0] d);
    @(negedge clk); we = 1'b1; addr = RAW'(a); wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [AW-1:0] d);
    addr = RAW'(a); #1; d = rdata;
  endtask

  task automatic pulse();
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic xfer(input logic [AW-1:0] exp);
    expq.push_back(exp);
    pulse();
    while (xfer_req) @(negedge clk);
  endtask

  task automatic rchk(input string tag, input int a, input logic [AW-1:0] exp);
    logic [AW-1:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  // monitor: pops expected destinations, acknowledges each transfer
  initial forever begin
    @(negedge clk);
    if (xfer_req === 1'b1) begin
      if (expq.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R4 unexpected transfer actual=%h expected=none", dst);
      end else begin
        chk("R4 dst", dst, expq.pop_front());
      end
      chk("R4 src", src, PADDR);
      repeat (ack_delay) @(negedge clk);
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_up();
  end

  initial begin
    logic [AW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 xfer_req", AW'(xfer_req), 0);
    chk("R1 irq", AW'(irq), 0);
    rchk("R1 stat", 10, 0);
    rchk("R1 sel", 0, 0);

    wr(2, PADDR); wr(3, 3); wr(4, IA); wr(5, IB);
    // R4 request with nothing active is ignored
    pulse(); @(negedge clk);
    chk("R4 idle ignored", AW'(xfer_req), 0);

    // one-shot A with interrupt enabled
    wr(1, 32'h10);
    wr(6, 32'hDEAD0); wr(8, 7);
    wr(0, 1);
    rchk("R2 sel A", 0, 1);
    rchk("R3 load addr A", 6, IA);
    rchk("R3 load cnt A", 8, 0);
    rd(10, v); chk("R9 busy A active", (v >> 4) & 1, 1);
    xfer(IA); xfer(IA + 4);
    rchk("R5 addr step", 6, IA + 8);
    rchk("R5 count step", 8, 2);
    xfer(IA + 8);
    rchk("R6 one-shot stop", 0, 0);
    rchk("R6 count at end", 8, 3);
    rd(10, v); chk("R11 full A", v & 1, 1);
    chk("R11 irq on", AW'(irq), 1);
    pulse(); @(negedge clk);
    chk("R6 no transfer after stop", AW'(xfer_req), 0);
    wr(10, 1);
    rd(10, v); chk("R11 full cleared", v & 1, 0);
    chk("R11 irq off", AW'(irq), 0);

    // auto-switch A then one-shot B, B interrupt only
    wr(1, 32'h21);
    wr(0, 1);
    xfer(IA); xfer(IA + 4); xfer(IA + 8);
    rchk("R7 switched to B", 0, 2);
    rchk("R7 B loaded", 6 + 1, IB);
    chk("R11 irq gated by enable", AW'(irq), 0);
    xfer(IB); xfer(IB + 4); xfer(IB + 8);
    rchk("R6 B stop", 0, 0);
    rd(10, v); chk("R11 full both", v & 3, 3);
    chk("R11 irq B", AW'(irq), 1);
    wr(10, 32'hF);

    // circular both
    wr(1, 32'hA);
    wr(0, 1);
    xfer(IA); xfer(IA + 4); xfer(IA + 8);
    rchk("R8 wrap cnt", 8, 0);
    rchk("R8 still active", 0, 1);
    xfer(IA);
    rchk("R8 count after wrap", 8, 1);
    wr(0, 2);
    rchk("R2 sel B", 0, 2);
    xfer(IB);
    rchk("R10 frozen cnt A", 8, 1);
    rchk("R10 frozen addr A", 6, IA + 4);
    wr(8, 0);
    rchk("R10 overwrite cnt A", 8, 0);
    wr(0, 2);
    rchk("R3 reselect keeps cnt B", 9, 1);
    wr(10, 32'hF);

    // busy drains after deselect
    ack_delay = 3;
    expq.push_back(IB + 4);
    pulse();
    wr(0, 0);
    rchk("R2 sel none", 0, 0);
    rd(10, v); chk("R9 busy B in flight", (v >> 5) & 1, 1);
    while (xfer_req) @(negedge clk);
    rd(10, v); chk("R9 busy B cleared", (v >> 5) & 1, 0);
    rchk("R5 late ack counted", 9, 2);

    // lost request, both-bits select picks A
    wr(0, 3);
    rchk("R2 both bits pick A", 0, 1);
    rchk("R3 reload A", 6, IA);
    expq.push_back(IA);
    @(negedge clk); req = 1'b1;
    @(negedge clk);
    @(negedge clk); req = 1'b0;
    while (xfer_req) @(negedge clk);
    rd(10, v); chk("R12 lost A set", (v >> 2) & 1, 1);
    rchk("R12 single transfer", 8, 1);
    wr(10, 4);
    rd(10, v); chk("R12 lost cleared", (v >> 2) & 1, 0);
    ack_delay = 0;
    repeat (4) @(negedge clk);
    chk("R4 queue drained", AW'(expq.size()), 0);
    finish_up();
  end

endmodule